// File: doc/BRIEF.md
# Thresholded Event Counter

This block is one performance-monitoring counter. Each clock it takes a small binary count of how many events happened in that cycle, together with a two-bit code for the privilege level the processor is running at. It decides how much to add, and adds it to a running count that is either 32 or 64 bits wide.

With a zero threshold the counter adds the raw per-cycle count. With a nonzero threshold it compares the per-cycle count against the threshold using one of four functions. On a cycle that meets the condition it adds either the raw count or exactly one. Counting can be switched off globally, and it can be suppressed per privilege level. A sticky overflow flag records every wrap of the configured width.

Software reaches the block through a flat register port. A write is a single-cycle strobe, and a read is a combinational mux. The port gives access to a control word, the count, a status word and a read-only capability word.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset the control word, the count and the status word read zero, and `ovf_flag` is low.
- R2: With the threshold field at zero, each counting cycle adds the raw `evt_cnt`, whatever the compare and count-by-one fields hold.
- R3: With a nonzero threshold, the control field at bits 6:5 selects the test of `evt_cnt` against the threshold: 0 not-equal, 1 equal, 2 greater-or-equal, 3 less-than. A cycle that passes adds `evt_cnt`, and a cycle that fails adds nothing.
- R4: With a nonzero threshold and control bit 7 set, a passing cycle adds exactly 1, even if `evt_cnt` is zero.
- R5: The threshold sits in control bits 19:8. A control write whose threshold exceeds `TH_MAX` keeps the previous threshold, applies the other fields and sets status bit 1. Status bit 1 is sticky and is cleared by writing 1 to it.
- R6: Address 3 reads `TH_MAX`, and writes to it have no effect.
- R7: Control bits 2, 3 and 4 suppress counting while `priv` is 0, 1 or 2 respectively. Level 3 is never suppressed.
- R8: While control bit 0 (enable) is clear, the count holds.
- R9: A write to address 1 loads the count. In that cycle the load takes precedence over any increment.
- R10: While control bit 1 is clear, the count wraps modulo 2^32 and its upper 32 bits read as zero, including bits left over from a 64-bit period or from a load.
- R11: A wrap of the configured width sets the overflow flag, which shows in status bit 0 and on `ovf_flag`. The flag stays set until 1 is written to status bit 0, and a wrap in the same cycle as the clear leaves it set.
- R12: While control bit 1 is set, the count carries across bit 32 without raising the overflow flag, and it wraps only at 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_cnt | input | EVT_W | Events seen in this cycle |
| priv | input | 2 | Current privilege level (0 user, 1 kernel, 2 hypervisor, 3 other) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 count, 2 status, 3 capability) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | CNT_W | Combinational read data |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `evt_cnt` and `priv` are settled at the rising edge. They also assume at most one register write per cycle, which the single write port guarantees. The single-step property for count-by-one mode compares only the low half of the count, so it holds in both widths and across a wrap. The bench changes inputs only on falling edges and keeps `evt_cnt` inside its four bits. Before each vector it loads the count through the write port, so that an increment from an idle cycle with zero events cannot leak into the next vector.

// File: rtl/evtc_pkg.sv
`timescale 1ns/1ps
package evtc_pkg;

   localparam int TH_FIELD_W = 12;

   typedef enum logic [1:0] {
      CMP_NE = 2'd0,
      CMP_EQ = 2'd1,
      CMP_GE = 2'd2,
      CMP_LT = 2'd3
   } cmp_fn_e;

   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_KERN = 2'd1,
      PRIV_HYP  = 2'd2,
      PRIV_TOP  = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      RA_CTRL   = 2'd0,
      RA_COUNT  = 2'd1,
      RA_STATUS = 2'd2,
      RA_CAPS   = 2'd3
   } reg_addr_e;

   // control word, LSB first: enable, wide, excl[2:0], cmp, count_one, thresh
   typedef struct packed {
      logic [TH_FIELD_W-1:0] thresh;
      logic                  count_one;
      logic [1:0]            cmp;
      logic [2:0]            excl;
      logic                  wide;
      logic                  enable;
   } ctrl_t;

endpackage

// File: rtl/evtc_filter.sv
`timescale 1ns/1ps
module evtc_filter
   import evtc_pkg::*;
(
   input  logic       enable,
   input  logic [2:0] excl,
   input  logic [1:0] priv,
   output logic       pass
);
   always_comb begin
      unique case (priv)
         PRIV_USER: pass = enable & ~excl[0];
         PRIV_KERN: pass = enable & ~excl[1];
         PRIV_HYP:  pass = enable & ~excl[2];
         default:   pass = enable;
      endcase
   end
endmodule

// File: rtl/evtc_thresh.sv
`timescale 1ns/1ps
module evtc_thresh
   import evtc_pkg::*;
#(
   parameter int EVT_W = 4,
   parameter int TH_W  = 12,
   parameter bit TH_EN = 1'b1
) (
   input  logic [EVT_W-1:0] evt,
   input  logic [TH_W-1:0]  th,
   input  logic [1:0]       cmp,
   input  logic             count_one,
   output logic [EVT_W-1:0] inc
);
   localparam int CW = (EVT_W > TH_W) ? EVT_W : TH_W;

   generate
      if (TH_EN) begin : g_thresh
         logic [CW-1:0] e_w, t_w;
         logic          hit;
         assign e_w = CW'(evt);
         assign t_w = CW'(th);
         always_comb begin
            unique case (cmp)
               CMP_NE:  hit = (e_w != t_w);
               CMP_EQ:  hit = (e_w == t_w);
               CMP_GE:  hit = (e_w >= t_w);
               default: hit = (e_w <  t_w);
            endcase
            if (th == '0)
               inc = evt;
            else if (!hit)
               inc = '0;
            else if (count_one)
               inc = EVT_W'(1);
            else
               inc = evt;
         end
      end else begin : g_raw
         assign inc = evt;
      end
   endgenerate
endmodule

// File: rtl/evtc_accum.sv
`timescale 1ns/1ps
module evtc_accum #(
   parameter int CNT_W = 64,
   parameter int EVT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step_en,
   input  logic [EVT_W-1:0] inc,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam int HALF_W = CNT_W / 2;

   logic [CNT_W-1:0] cnt_q, nxt;
   logic [HALF_W:0]  sum_lo;
   logic [CNT_W:0]   sum_full;
   logic             carry;

   assign sum_lo   = {1'b0, cnt_q[HALF_W-1:0]} + (HALF_W+1)'(inc);
   assign sum_full = {1'b0, cnt_q} + (CNT_W+1)'(inc);

   always_comb begin
      if (wide) begin
         nxt   = sum_full[CNT_W-1:0];
         carry = sum_full[CNT_W];
      end else begin
         nxt   = {{HALF_W{1'b0}}, sum_lo[HALF_W-1:0]};
         carry = sum_lo[HALF_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= wide ? load_val : {{HALF_W{1'b0}}, load_val[HALF_W-1:0]};
      else if (step_en)
         cnt_q <= nxt;
   end

   assign cnt  = cnt_q;
   assign wrap = step_en & ~load & carry;
endmodule

// File: rtl/evt_thresh_counter.sv
`timescale 1ns/1ps
module evt_thresh_counter
   import evtc_pkg::*;
#(
   parameter int EVT_W  = 4,
   parameter int TH_MAX = 255,
   parameter int CNT_W  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_cnt,
   input  logic [1:0]       priv,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             ovf_flag
);
   localparam int TH_W   = TH_FIELD_W;
   localparam int HALF_W = CNT_W / 2;
   localparam int CTRL_W = $bits(ctrl_t);
   localparam bit TH_EN  = (TH_MAX != 0);
   localparam logic [TH_W-1:0] TH_LIM = TH_W'(TH_MAX);

   generate
      if (TH_MAX < 0 || TH_MAX > (1 << TH_W) - 1) begin : g_bad_thmax
         $error("TH_MAX must fit the threshold field");
      end
      if (CNT_W < 2 * CTRL_W || (CNT_W % 2) != 0) begin : g_bad_cntw
         $error("CNT_W must be even and hold the control word");
      end
      if (EVT_W < 1 || EVT_W > CNT_W / 2) begin : g_bad_evtw
         $error("EVT_W must be between 1 and CNT_W/2");
      end
   endgenerate

   ctrl_t            ctrl_q, ctrl_nxt;
   logic             ovf_q, therr_q, th_bad;
   logic             wr_ctrl, wr_count, wr_status;
   logic             pass, acc_wrap;
   logic [EVT_W-1:0] inc;
   logic [CNT_W-1:0] cnt_q;

   assign wr_ctrl   = wr_en && (wr_addr == RA_CTRL);
   assign wr_count  = wr_en && (wr_addr == RA_COUNT);
   assign wr_status = wr_en && (wr_addr == RA_STATUS);

   always_comb begin
      ctrl_nxt = ctrl_t'(wr_data[CTRL_W-1:0]);
      th_bad   = (ctrl_nxt.thresh > TH_LIM);
      if (th_bad)
         ctrl_nxt.thresh = ctrl_q.thresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         therr_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= ctrl_nxt;
            if (th_bad)
               therr_q <= 1'b1;
         end else if (wr_status && wr_data[1]) begin
            therr_q <= 1'b0;
         end
         ovf_q <= acc_wrap | (ovf_q & ~(wr_status & wr_data[0]));
      end
   end

   evtc_filter filt_i (
      .enable (ctrl_q.enable),
      .excl   (ctrl_q.excl),
      .priv   (priv),
      .pass   (pass)
   );

   evtc_thresh #(.EVT_W(EVT_W), .TH_W(TH_W), .TH_EN(TH_EN)) thr_i (
      .evt       (evt_cnt),
      .th        (ctrl_q.thresh),
      .cmp       (ctrl_q.cmp),
      .count_one (ctrl_q.count_one),
      .inc       (inc)
   );

   evtc_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (ctrl_q.wide),
      .load     (wr_count),
      .load_val (wr_data),
      .step_en  (pass),
      .inc      (inc),
      .cnt      (cnt_q),
      .wrap     (acc_wrap)
   );

   always_comb begin
      unique case (rd_addr)
         RA_CTRL:   rd_data = CNT_W'(ctrl_q);
         RA_COUNT:  rd_data = ctrl_q.wide ? cnt_q : {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]};
         RA_STATUS: rd_data = CNT_W'({therr_q, ovf_q});
         default:   rd_data = CNT_W'(TH_MAX);
      endcase
   end

   assign ovf_flag = ovf_q;
endmodule

// File: rtl/evtc_checker.sv
`timescale 1ns/1ps
module evtc_checker
   import evtc_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int TH_MAX = 255
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       priv,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic [1:0]       rd_addr,
   input logic [CNT_W-1:0] rd_data,
   input ctrl_t            ctrl_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ovf_flag
);
   localparam int HALF_W = CNT_W / 2;
   logic cnt_wr;
   assign cnt_wr = wr_en && (wr_addr == RA_COUNT);

   p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.enable && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

   p_excl_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == PRIV_USER && ctrl_q.excl[0] && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

   p_excl_hyp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == PRIV_HYP && ctrl_q.excl[2] && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

   p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_COUNT && !ctrl_q.wide) |-> (rd_data[CNT_W-1:HALF_W] == '0));

   p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !(wr_en && wr_addr == RA_STATUS && wr_data[0])) |=> ovf_flag);

   p_th_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ctrl_q.thresh) <= TH_MAX));

   p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.count_one && ctrl_q.thresh != '0 && !cnt_wr)
      |=> (HALF_W'(cnt_q[HALF_W-1:0] - $past(cnt_q[HALF_W-1:0])) <= HALF_W'(1)));

   p_caps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_CAPS) |-> (rd_data == CNT_W'(TH_MAX)));

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && ctrl_q.wide) |=> (cnt_q == $past(wr_data)));
endmodule

bind evt_thresh_counter evtc_checker #(.CNT_W(CNT_W), .TH_MAX(TH_MAX)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .priv     (priv),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .rd_addr  (rd_addr),
   .rd_data  (rd_data),
   .ctrl_q   (ctrl_q),
   .cnt_q    (cnt_q),
   .ovf_flag (ovf_flag)
);

// File: tb/evt_thresh_counter_tb_top.sv
`timescale 1ns/1ps
module evt_thresh_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  evt_cnt = '0;
   logic [1:0]  priv = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic        ovf_flag;
   int          nvec = 0;
   int          nerr = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   evt_thresh_counter #(.EVT_W(4), .TH_MAX(255), .CNT_W(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv(priv),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_ctrl(input bit en, input bit wide, input int excl,
                                           input int cmp, input bit one, input int th);
      logic [63:0] v;
      v = '0;
      v[0]    = en;
      v[1]    = wide;
      v[4:2]  = 3'(excl);
      v[6:5]  = 2'(cmp);
      v[7]    = one;
      v[19:8] = 12'(th);
      return v;
   endfunction

   function automatic int exp_inc(input int cmp, input bit one, input int th, input int e);
      bit hit;
      if (th == 0) return e;
      case (cmp)
         0: hit = (e != th);
         1: hit = (e == th);
         2: hit = (e >= th);
         default: hit = (e < th);
      endcase
      if (!hit) return 0;
      return one ? 1 : e;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; evt_cnt = '0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [63:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // load count, apply one cycle of events, then read the count
   task automatic vec(input logic [63:0] base, input logic [3:0] e, input logic [1:0] p,
                      input logic [63:0] exp, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = base; evt_cnt = '0; rd_addr = 2'd1;
      @(negedge clk);
      wr_en = 1'b0; evt_cnt = e; priv = p;
      @(negedge clk);
      evt_cnt = '0;
      #1;
      chk(req, rd_data, exp);
   endtask

   initial begin
      #800000;
      nerr++;
      $display("FAIL watchdog expired");
      if (!done) summary();
      $finish;
   end

   initial begin
      logic [63:0] d;
      int ths[6];
      ths = '{0, 1, 2, 7, 15, 255};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", d, 64'd0);
      rd(2'd1, d); chk("R1 count", d, 64'd0);
      rd(2'd2, d); chk("R1 status", d, 64'd0);
      chk("R1 ovf_flag", {63'd0, ovf_flag}, 64'd0);
      rd(2'd3, d); chk("R6 caps", d, 64'd255);

      // R2/R3/R4 threshold sweep in 64-bit mode
      for (int ti = 0; ti < 6; ti++)
         for (int c = 0; c < 4; c++)
            for (int o = 0; o < 2; o++) begin
               wr(2'd0, mk_ctrl(1, 1, 0, c, o[0], ths[ti]));
               for (int e = 0; e < 16; e++)
                  vec(64'd100, 4'(e), 2'd3, 64'(100 + exp_inc(c, o[0], ths[ti], e)),
                      (ths[ti] == 0) ? "R2" : (o[0] ? "R4" : "R3"));
            end

      // R7 privilege exclusion sweep
      for (int x = 0; x < 8; x++) begin
         wr(2'd0, mk_ctrl(1, 1, x, 0, 0, 0));
         for (int p = 0; p < 4; p++) begin
            bit ex;
            ex = (p == 0 && x[0]) || (p == 1 && x[1]) || (p == 2 && x[2]);
            vec(64'd40, 4'd3, 2'(p), ex ? 64'd40 : 64'd43, "R7");
         end
      end

      // R8 enable clear holds
      wr(2'd0, mk_ctrl(0, 1, 0, 0, 0, 0));
      vec(64'd77, 4'd5, 2'd0, 64'd77, "R8");

      // R9 load beats increment in the same cycle
      wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0));
      @(negedge clk);
      evt_cnt = 4'd5; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 64'd10; rd_addr = 2'd1;
      @(negedge clk);
      wr_en = 1'b0; evt_cnt = '0;
      #1 chk("R9 load priority", rd_data, 64'd10);

      // R5 threshold above limit rejected
      wr(2'd0, mk_ctrl(1, 1, 0, 2, 0, 2));
      wr(2'd0, mk_ctrl(1, 1, 0, 1, 0, 300));
      rd(2'd0, d); chk("R5 thresh kept", {52'd0, d[19:8]}, 64'd2);
      chk("R5 cmp applied", {62'd0, d[6:5]}, 64'd1);
      rd(2'd2, d); chk("R5 error bit", d, 64'd2);
      vec(64'd0, 4'd2, 2'd0, 64'd2, "R5 eq with kept threshold");
      vec(64'd0, 4'd3, 2'd0, 64'd0, "R5 eq miss");
      wr(2'd2, 64'd2);
      rd(2'd2, d); chk("R5 error cleared", d, 64'd0);
      wr(2'd0, mk_ctrl(1, 1, 0, 2, 0, 255));
      rd(2'd0, d); chk("R5 max accepted", {52'd0, d[19:8]}, 64'd255);
      rd(2'd2, d); chk("R5 no error", d, 64'd0);

      // R6 capability write ignored
      wr(2'd3, 64'd0);
      rd(2'd3, d); chk("R6 caps after write", d, 64'd255);

      // R10/R11 narrow mode wrap and flag
      wr(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0));
      vec(64'hFFFF_FFFE, 4'd3, 2'd0, 64'd1, "R10 narrow wrap");
      chk("R11 ovf_flag set", {63'd0, ovf_flag}, 64'd1);
      rd(2'd2, d); chk("R11 status ovf", d, 64'd1);
      vec(64'h5_0000_0010, 4'd0, 2'd0, 64'h10, "R10 upper zero after load");
      chk("R11 sticky", {63'd0, ovf_flag}, 64'd1);
      wr(2'd2, 64'd1);
      chk("R11 cleared", {63'd0, ovf_flag}, 64'd0);
      vec(64'hFFFF_FFFF, 4'd0, 2'd0, 64'hFFFF_FFFF, "R10 no wrap");
      @(negedge clk);
      evt_cnt = 4'd1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 64'd1;
      @(negedge clk);
      wr_en = 1'b0; evt_cnt = '0; rd_addr = 2'd1;
      #1;
      chk("R11 set beats clear", {63'd0, ovf_flag}, 64'd1);
      chk("R10 wrapped to zero", rd_data, 64'd0);
      wr(2'd2, 64'd1);

      // R12 wide mode carries across bit 32
      wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0));
      vec(64'hFFFF_FFFF, 4'd1, 2'd0, 64'h1_0000_0000, "R12 carry");
      chk("R12 no ovf", {63'd0, ovf_flag}, 64'd0);
      vec(64'hFFFF_FFFF_FFFF_FFFF, 4'd2, 2'd0, 64'd1, "R12 full wrap");
      chk("R12 ovf at 2^64", {63'd0, ovf_flag}, 64'd1);
      wr(2'd2, 64'd1);

      // R10 switch to narrow hides stale upper bits
      vec(64'h3_0000_0005, 4'd0, 2'd0, 64'h3_0000_0005, "R12 wide load");
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0));
      rd(2'd1, d); chk("R10 upper masked", d, 64'd5);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule